// File: doc/BRIEF.md
# Serial-Bus Control Register File

This block is the control-port slave of an audio converter. A host reaches it over a two-wire serial bus (I2C) and reads or writes three 8-bit control registers: a power-enable register, an input-source register and a clock/format/mute register. The register fields leave the block as plain static outputs that the rest of the converter uses directly.

Both bus lines are oversampled with the local system clock. The clock must run at least 16 times faster than the bus clock. Each line passes through a two-flop synchroniser. The block then finds the SCL edges and the start and stop conditions from the synchronised copies. The slave never drives a line high. It only pulls SDA low through `sda_oe_o`, and the pad must turn that into an open-drain output. Bus transfers carry no back-pressure. The slave never stretches the clock and always answers within one bus bit time.

A write carries the device address, then a pointer byte, then any number of data bytes. A read returns the register at the current pointer and keeps going for as long as the host acknowledges. The 2-bit pointer keeps its value across transactions, so a bare read resumes where the last access stopped.

Top module: `ctl_i2c_regfile`

## Requirements
- R1: The slave answers only to the 7-bit address 0110001, sent MSB first and followed by the direction bit (0 = write, 1 = read). So 62h selects a write and 63h a read. It acknowledges a matching address by holding SDA low during the ninth clock. For any other address it gives no acknowledge and ignores all bytes until the next start.
- R2: While `rst_n_i` is low the registers return to their defaults and the pointer returns to 00h. The defaults are: register 00h = 01h, register 01h = 04h, register 02h = 00h.
- R3: In a write, bits 1:0 of the byte after the address load the pointer. Each data byte goes to the register the pointer selects, with these field positions: register 00h bit 0 = `pwr_on_o`; register 01h bits 2:0 = `in_sel_o`; register 02h bit 4 = `fmt_o`, bits 3:1 = `mode_o`, bit 0 = `mute_o`. Registers change only through such writes.
- R4: In a write, the address byte, the pointer byte and every data byte are all acknowledged.
- R5: After each data byte is written the pointer advances by one. From 02h (or 03h) it wraps to 00h.
- R6: A read that is not preceded by a pointer write returns the register at the current pointer and then advances the pointer. The pointer keeps its value across stop conditions.
- R7: A pointer write followed by a repeated start and a read address returns the selected register first. Further bytes follow while the host acknowledges, and the pointer wraps from 02h to 00h.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more in that transaction. No register changes.
- R9: Unused register bits are always read back as 0, even after 1s are written to them.
- R10: A data byte written at pointer 03h is acknowledged but changes no register. A read at pointer 03h returns 00h.
- R11: Clearing the power bit leaves the other registers unchanged.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 16x the bus clock |
| rst_n_i | input | 1 | Active-low power-down reset; restores register defaults |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low; 0 = release |
| pwr_on_o | output | 1 | Power-enable bit |
| in_sel_o | output | 3 | Input-source select |
| fmt_o | output | 1 | Audio data format select |
| mode_o | output | 3 | Clocking mode select |
| mute_o | output | 1 | Soft-mute request |

## Verification
The bench attacks the pointer corner cases:
- **Wrap on burst write and burst read.** A design that counts to 03h would send the fourth byte of a burst to nowhere, or would read back 00h in place of register 00h.
- **Pointer that survives a stop.** A design that clears the pointer at each start would return register 00h from every current-address read.
- **The 03h hole.** A design that decodes only the low pointer bit would overwrite register 01h when the host writes at 03h.

It also writes all-ones to every register and checks that no unused bit reads back as 1. It checks that a foreign address leaves every field unchanged. It watches for any change of the SDA drive while the bench holds SCL high, which is the fault that would turn a slave acknowledge into a false start or stop.

// File: rtl/ctl_i2c_pkg.sv
`timescale 1ns/1ps
package ctl_i2c_pkg;
  localparam logic [6:0] DEV_ADDR = 7'b0110001;
  localparam int PTR_W    = 2;
  localparam int NUM_REGS = 3;
  localparam int DATA_W   = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } bus_st_e;

  // writable bits of each register
  function automatic logic [DATA_W-1:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'h01;
      1:       return 8'h07;
      2:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_dflt(input int idx);
    case (idx)
      0:       return 8'h01;
      1:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR = DEV_ADDR,
  parameter int PW = PTR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          ptr_ld_o,
  output logic [PW-1:0] ptr_val_o,
  output logic          ptr_inc_o
);
  localparam int CW = $clog2(DW + 1);

  bus_st_e        st;
  logic [CW-1:0]  bit_cnt;
  logic [DW-1:0]  rx_sh, tx_sh;
  logic           rw_q, nack_q, ack_q;
  logic           byte_done, rd_take;

  assign byte_done = scl_fall && (bit_cnt == CW'(DW));
  assign wr_en_o   = (st == ST_WDAT) && byte_done;
  assign ptr_ld_o  = (st == ST_PTR) && byte_done;
  assign ptr_val_o = rx_sh[PW-1:0];
  assign wr_data_o = rx_sh;
  assign rd_take   = scl_fall && (((st == ST_ADDR_ACK) && rw_q) ||
                                  ((st == ST_RACK) && !nack_q));
  assign ptr_inc_o = wr_en_o || rd_take;
  assign sda_oe_o  = (st == ST_RDAT) ? ~tx_sh[DW-1] : ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      ack_q   <= 1'b0;
    end else if (start_det) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      ack_q   <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      ack_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && (bit_cnt != CW'(DW))) begin
            rx_sh   <= {rx_sh[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_done) begin
            bit_cnt <= '0;
            if (st == ST_ADDR) begin
              if (rx_sh[DW-1:1] == ADDR) begin
                rw_q  <= rx_sh[0];
                ack_q <= 1'b1;
                st    <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              ack_q <= 1'b1;
              st    <= (st == ST_PTR) ? ST_PTR_ACK : ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            if (rw_q) begin
              tx_sh <= rd_data_i;
              st    <= ST_RDAT;
            end else begin
              st <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            st    <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_cnt == CW'(DW - 1)) begin
              bit_cnt <= '0;
              tx_sh   <= '1;
              nack_q  <= 1'b1;
              st      <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[DW-2:0], 1'b1};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_q <= sda_s;
          if (scl_fall) begin
            if (!nack_q) begin
              tx_sh <= rd_data_i;
              st    <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank
  import ctl_i2c_pkg::*;
#(
  parameter int NR = NUM_REGS,
  parameter int PW = PTR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ptr_ld_i,
  input  logic [PW-1:0] ptr_val_i,
  input  logic          ptr_inc_i,
  output logic [DW-1:0] rd_data_o,
  output logic [PW-1:0] ptr_o,
  output logic          pwr_on_o,
  output logic [2:0]    in_sel_o,
  output logic          fmt_o,
  output logic [2:0]    mode_o,
  output logic          mute_o
);
  localparam logic [PW-1:0] LAST = PW'(NR - 1);

  logic [DW-1:0] regs [NR];
  logic [PW-1:0] ptr_q;

  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= reg_dflt(g);
      else if (wr_en_i && (ptr_q == PW'(g)))
        regs[g] <= wr_data_i & reg_mask(g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (ptr_ld_i)  ptr_q <= ptr_val_i;
    else if (ptr_inc_i) ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NR; i++)
      if (ptr_q == PW'(i)) rd_data_o = regs[i];
  end

  assign ptr_o    = ptr_q;
  assign pwr_on_o = regs[0][0];
  assign in_sel_o = regs[1][2:0];
  assign fmt_o    = regs[2][4];
  assign mode_o   = regs[2][3:1];
  assign mute_o   = regs[2][0];
endmodule

// File: rtl/ctl_i2c_regfile.sv
`timescale 1ns/1ps
module ctl_i2c_regfile
  import ctl_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = DEV_ADDR
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       pwr_on_o,
  output logic [2:0] in_sel_o,
  output logic       fmt_o,
  output logic [2:0] mode_o,
  output logic       mute_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, ptr_ld, ptr_inc;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [PTR_W-1:0]  ptr_val, ptr_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk_i), .rst_n(rst_n_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.ADDR(SLAVE_ADDR), .PW(PTR_W), .DW(DATA_W)) fsm_i (
    .clk(clk_i), .rst_n(rst_n_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
    .wr_en_o(wr_en), .wr_data_o(wr_data),
    .ptr_ld_o(ptr_ld), .ptr_val_o(ptr_val), .ptr_inc_o(ptr_inc)
  );

  ctl_reg_bank #(.NR(NUM_REGS), .PW(PTR_W), .DW(DATA_W)) bank_i (
    .clk(clk_i), .rst_n(rst_n_i),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ptr_ld_i(ptr_ld), .ptr_val_i(ptr_val), .ptr_inc_i(ptr_inc),
    .rd_data_o(rd_data), .ptr_o(ptr_q),
    .pwr_on_o(pwr_on_o), .in_sel_o(in_sel_o), .fmt_o(fmt_o),
    .mode_o(mode_o), .mute_o(mute_o)
  );
endmodule

// File: rtl/ctl_i2c_regfile_chk.sv
`timescale 1ns/1ps
module ctl_i2c_regfile_chk #(
  parameter int PW = 2,
  parameter int NR = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          wr_en,
  input logic          ptr_inc,
  input logic [PW-1:0] ptr,
  input logic          pwr_on,
  input logic [2:0]    in_sel,
  input logic          fmt,
  input logic [2:0]    mode,
  input logic          mute
);
  localparam logic [PW-1:0] LAST = PW'(NR - 1);

  logic rst_held;
  always_ff @(posedge clk) rst_held <= !rst_n;

  // R2: defaults held while reset has been low for a full cycle
  always @(posedge clk) begin
    if (!rst_n && rst_held === 1'b1)
      assert_reset_defaults_R2: assert (pwr_on && in_sel == 3'b100 && !fmt &&
                                        mode == 3'b000 && !mute)
        else $error("register defaults not applied in reset");
  end

  // R5: pointer wraps to zero past the last register
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr >= LAST) |=> (ptr == '0));

  // R3: register fields move only on a write strobe
  assert_regs_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({pwr_on, in_sel, fmt, mode, mute}));

  // R12: the slave begins pulling SDA only while SCL is low
  assert_oe_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R12: the slave lets go of SDA only while SCL is low
  assert_oe_fall_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  // R3: register writes land in the SCL-low phase
  assert_write_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);
endmodule

bind ctl_i2c_regfile ctl_i2c_regfile_chk #(.PW(2), .NR(3)) chk_i (
  .clk(clk_i), .rst_n(rst_n_i), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .wr_en(wr_en), .ptr_inc(ptr_inc), .ptr(ptr_q),
  .pwr_on(pwr_on_o), .in_sel(in_sel_o), .fmt(fmt_o), .mode(mode_o), .mute(mute_o)
);

// File: tb/ctl_i2c_regfile_tb_top.sv
`timescale 1ns/1ps
module ctl_i2c_regfile_tb_top;
  localparam int Q = 10;
  localparam int WDOG = 190000;
  localparam logic [7:0] AW = 8'h62;
  localparam logic [7:0] AR = 8'h63;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_low;
  logic sda_oe_o, pwr_on_o, fmt_o, mute_o;
  logic [2:0] in_sel_o, mode_o;
  wire sda_bus = ~(m_low | sda_oe_o);

  int checks = 0;
  int errors = 0;
  int scl_hi_changes = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  ctl_i2c_regfile dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .pwr_on_o(pwr_on_o), .in_sel_o(in_sel_o),
    .fmt_o(fmt_o), .mode_o(mode_o), .mute_o(mute_o)
  );

  // watch for slave SDA changes during SCL-high phases (R12)
  always @(negedge clk) begin
    if (sda_oe_o !== oe_prev) begin
      if (m_scl === 1'b1) scl_hi_changes++;
      oe_prev = sda_oe_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_low = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(Q);
      m_scl = 1'b1;  hold(Q);
      m_scl = 1'b0;  hold(Q);
    end
    m_low = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q/2);
    ack = ~sda_bus; hold(Q/2);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; hold(Q);
      m_scl = 1'b1; hold(Q/2);
      b[i] = sda_bus; hold(Q/2);
      m_scl = 1'b0; hold(Q);
    end
    m_low = give_ack; hold(Q);
    m_scl = 1'b1;     hold(Q);
    m_scl = 1'b0;     hold(Q);
    m_low = 1'b0;
  endtask

  task automatic write1(input logic [7:0] ptr, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(AW, a0); send_byte(ptr, a1); send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rand_read1(input logic [7:0] ptr, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(AW, a0); send_byte(ptr, a1);
    bus_start();
    send_byte(AR, a2);
    recv_byte(1'b0, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic cur_read1(output logic [7:0] d, output logic ok);
    bus_start();
    send_byte(AR, ok);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  // {kind(0 = write then read back, 1 = read only), ptr, data, expected}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'hFE, 8'h00},
    {2'd0, 2'd1, 8'hFB, 8'h03},
    {2'd0, 2'd2, 8'hFF, 8'h1F},
    {2'd0, 2'd2, 8'h15, 8'h15},
    {2'd0, 2'd3, 8'hAA, 8'h00},
    {2'd1, 2'd1, 8'h00, 8'h03},
    {2'd1, 2'd2, 8'h00, 8'h15},
    {2'd0, 2'd0, 8'h81, 8'h01}
  };

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok, a0, a1, a2, a3, a4;
    logic [7:0] d;
    rst_n = 1'b0; m_scl = 1'b1; m_low = 1'b0;
    hold(5);
    // R2: defaults in reset
    chk("R2 reset pwr_on", pwr_on_o, 1);
    chk("R2 reset in_sel", in_sel_o, 3'b100);
    chk("R2 reset cfg", {fmt_o, mode_o, mute_o}, 0);
    rst_n = 1'b1;
    hold(5);

    // R1: foreign address gets no ack, following bytes ignored
    bus_start();
    send_byte(8'h64, a0); send_byte(8'h01, a1); send_byte(8'h00, a2);
    bus_stop();
    chk("R1 foreign address nack", a0, 0);
    chk("R1 foreign write ignored", {pwr_on_o, in_sel_o}, 4'b1100);

    // table walk: R3 field writes, R9 unused bits, R10 hole at 03h
    for (int v = 0; v < NV; v++) begin
      logic [7:0] got;
      logic okw;
      okw = 1'b1;
      if (VEC[v][19:18] == 2'd0) write1({6'b0, VEC[v][17:16]}, VEC[v][15:8], okw);
      rand_read1({6'b0, VEC[v][17:16]}, got, ok);
      chk($sformatf("R4 acks row %0d", v), okw & ok, 1);
      chk($sformatf("R3/R9/R10 readback row %0d", v), got, VEC[v][7:0]);
    end
    chk("R3 fields pwr/sel", {pwr_on_o, in_sel_o}, 4'b1011);
    chk("R3 fields fmt/mode/mute", {fmt_o, mode_o, mute_o}, 5'b10101);

    // R5 / R11: burst write from 01h wraps through 02h to 00h and 01h
    bus_start();
    send_byte(AW, a0); send_byte(8'h01, a1);
    send_byte(8'h02, a2); send_byte(8'h0E, a3); send_byte(8'h00, a4);
    send_byte(8'h01, ok);
    bus_stop();
    chk("R4 burst acks", {a0, a1, a2, a3, a4, ok}, 6'b111111);
    chk("R5 wrap write reached 00h", pwr_on_o, 0);
    chk("R5 second pass over 01h", in_sel_o, 3'd1);
    chk("R11 power off keeps cfg", {fmt_o, mode_o, mute_o}, 5'b01110);

    // R6: current reads continue from pointer 02h across stops
    cur_read1(d, ok);
    chk("R6 current read at 02h", {ok, d}, 9'h10E);
    cur_read1(d, ok);
    chk("R6 pointer kept over stop", {ok, d}, 9'h100);

    // R7 / R8: random burst read from 02h with wrap, ending in nack
    bus_start();
    send_byte(AW, a0); send_byte(8'h02, a1);
    bus_start();
    send_byte(AR, a2);
    recv_byte(1'b1, d); chk("R7 first byte 02h", d, 8'h0E);
    recv_byte(1'b1, d); chk("R7 wrapped to 00h", d, 8'h00);
    recv_byte(1'b1, d); chk("R7 then 01h", d, 8'h01);
    recv_byte(1'b0, d); chk("R7 then 02h", d, 8'h0E);
    hold(Q);
    chk("R8 released after nack", sda_oe_o, 0);
    bus_stop();
    chk("R8 registers unchanged", {pwr_on_o, in_sel_o, fmt_o, mode_o, mute_o}, 9'b0_001_01110);
    chk("R7 acks", {a0, a1, a2}, 3'b111);

    // R2: reset after activity restores defaults and pointer
    rst_n = 1'b0; hold(5);
    rst_n = 1'b1; hold(5);
    chk("R2 defaults after reset", {pwr_on_o, in_sel_o, fmt_o, mode_o, mute_o}, 9'b1_100_00000);
    cur_read1(d, ok);
    chk("R2 pointer cleared", {ok, d}, 9'h101);

    chk("R12 SDA changes while SCL high", scl_hi_changes, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule